// File: doc/BRIEF.md
# Dual Tone Output Conditioner

This block turns two raw tone-present decisions, already sampled in the system clock domain, into two conditioned digital outputs. Each channel runs on its own. The mode input and the bus-release input are shared by both channels.

With the mode input high, each output follows its channel's tone decision, delayed by one clock. With the mode input low, each output is qualified by an up/down integrator. The integrator counts up on cycles with tone and down on cycles without tone. It saturates at zero and at a top value of `WIN_TICKS`, which is fixed when the design is built. The output rises when the count reaches the top value and falls when the count drains back to zero. Short gaps in the tone therefore do not restart the count, and short bursts do not release the output.

When the release input is high, both outputs stop driving the shared line, so several such blocks can share one bus. High impedance is modelled as a separate drive-enable output. A change of mode clears both integrators.

Each channel's packet logic is a four-state machine:
- `PK_QUIET`: output low, count zero.
- `PK_BUILD`: output low, count between zero and the top.
- `PK_ACTIVE`: output high, count at the top.
- `PK_DECAY`: output high, count below the top.

The transitions are:
- quiet→build on a tone cycle.
- build→active when a tone cycle lifts the count to the top.
- build→quiet when a silent cycle brings the count to zero.
- active→decay on a silent cycle.
- decay→active when a tone cycle restores the top.
- decay→quiet when a silent cycle reaches zero.
- any state→quiet on a mode change.

The shared mode controller has two states:
- `MD_PACKET` and `MD_FOLLOW`.
- It moves between them whenever the mode input differs from the stored state, and that cycle clears both integrators.

Top module: `tone_out_cond`

## Requirements
- R1: The two channels are independent. Channel n's output depends only on `tone_in[n]`, where bit 0 is channel 0 and bit 1 is channel 1.
- R2: While `out_sel` is 1 (follower mode), `ch_out[n]` equals the value `tone_in[n]` had at the previous rising clock edge.
- R3: While `out_sel` is 0 (packet mode), a channel output rises at the clock edge at which its integrator reaches `WIN_TICKS`. The integrator reaches that value after `WIN_TICKS` more tone cycles than silent cycles have been counted since it last stood at zero.
- R4: In packet mode, a high output falls at the edge at which its integrator drains to zero, one count per silent cycle.
- R5: The integrator saturates. Tone cycles at the top value do not raise it further, so a fully charged channel always releases after exactly `WIN_TICKS` net silent cycles.
- R6: Hysteresis: between zero and the top value, a packet output keeps its previous level.
- R7: At the edge where `out_sel` differs from its value at the previous edge, both integrators are cleared. In packet mode both outputs are then low, even if tone is present.
- R8: `ch_drv` is 0 one clock after `hiz_req` is 1 and is 1 one clock after `hiz_req` is 0. This applies to both channels together.
- R9: While `rst_n` is low, `ch_out` is all zeros, `ch_drv` is 0, and the integrators are zero. The stored mode after reset is packet mode.
- R10: `WIN_TICKS` is a build-time parameter of at least 2. Its default is 40 ms of a 3.579545 MHz clock, computed as 3579 × 40 = 143160 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_in | input | NUM_CH | Raw tone-present decision per channel |
| out_sel | input | 1 | 1 = follower mode, 0 = packet mode |
| hiz_req | input | 1 | 1 = release both outputs (high impedance) |
| ch_out | output | NUM_CH | Conditioned output level per channel |
| ch_drv | output | 1 | Drive enable for both outputs; 0 models high impedance |

## Verification
A wrong integrator count does not show at once: it shows as an output edge that comes early or late. A count that fails to saturate, for example, delays the release by the number of extra tone cycles. Checking every cycle of a charge, hold and drain sequence catches such a fault within `WIN_TICKS` cycles of its cause. A stale state after a mode change, or a wrong drive-enable, shows at the ports on the very next clock. Interleaved tone patterns on the two channels expose any crossing of state between them.

// File: rtl/tdo_pkg.sv
package tdo_pkg;

    typedef enum logic [1:0] {
        PK_QUIET  = 2'd0,
        PK_BUILD  = 2'd1,
        PK_ACTIVE = 2'd2,
        PK_DECAY  = 2'd3
    } pk_state_e;

    typedef enum logic {
        MD_PACKET = 1'b0,
        MD_FOLLOW = 1'b1
    } md_state_e;

    function automatic int unsigned win_ticks(input int unsigned clk_hz,
                                              input int unsigned win_ms);
        return (clk_hz / 1000) * win_ms;
    endfunction

endpackage

// File: rtl/tdo_mode_ctrl.sv
module tdo_mode_ctrl
    import tdo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic out_sel,
    input  logic hiz_req,
    output logic mode_clr,
    output logic drv_q
);

    md_state_e md_q;
    md_state_e md_nx;

    // Next mode taken straight from the select input
    always_comb begin
        md_nx = out_sel ? MD_FOLLOW : MD_PACKET;
    end

    // Clear pulse for the integrators on the cycle the mode changes
    always_comb begin
        mode_clr = 1'b0;
        unique case (md_q)
            MD_PACKET: mode_clr = (md_nx == MD_FOLLOW);
            MD_FOLLOW: mode_clr = (md_nx == MD_PACKET);
        endcase
    end

    // Mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_q <= MD_PACKET;
        end else begin
            md_q <= md_nx;
        end
    end

    // Shared drive-enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= 1'b0;
        end else begin
            drv_q <= ~hiz_req;
        end
    end

    assert_drive_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_req |=> !drv_q);

    assert_drive_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hiz_req |=> drv_q);

    assert_clr_follows_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr |=> !mode_clr || (out_sel != $past(out_sel)));

endmodule

// File: rtl/tdo_integrator.sv
module tdo_integrator #(
    parameter int unsigned TOP_VAL = 4,
    localparam int unsigned CW     = $clog2(TOP_VAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tone,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] TOP = CW'(TOP_VAL);

    // Saturating up/down count of tone against silence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tone && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end else if (!tone && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt)));

    assert_cnt_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

endmodule

// File: rtl/tdo_channel.sv
module tdo_channel
    import tdo_pkg::*;
#(
    parameter int unsigned TOP_VAL = 4,
    localparam int unsigned CW     = $clog2(TOP_VAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone,
    input  logic follow,
    input  logic clr,
    output logic ch_out
);

    localparam logic [CW-1:0] TOP     = CW'(TOP_VAL);
    localparam logic [CW-1:0] TOP_M1  = CW'(TOP_VAL - 1);
    localparam logic [CW-1:0] ONE     = CW'(1);

    logic [CW-1:0] cnt;
    pk_state_e     st_q;
    pk_state_e     st_nx;
    logic          pk_hi_nx;
    logic          pk_hi_q;

    tdo_integrator #(
        .TOP_VAL (TOP_VAL)
    ) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tone  (tone),
        .cnt   (cnt)
    );

    // Packet state transitions, tracking the integrator one step ahead
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PK_QUIET: begin
                if (tone) st_nx = PK_BUILD;
            end
            PK_BUILD: begin
                if (tone && (cnt == TOP_M1))      st_nx = PK_ACTIVE;
                else if (!tone && (cnt == ONE))   st_nx = PK_QUIET;
            end
            PK_ACTIVE: begin
                if (!tone) st_nx = PK_DECAY;
            end
            PK_DECAY: begin
                if (tone && (cnt == TOP_M1))      st_nx = PK_ACTIVE;
                else if (!tone && (cnt == ONE))   st_nx = PK_QUIET;
            end
        endcase
        if (clr) st_nx = PK_QUIET;
    end

    assign pk_hi_nx = (st_nx == PK_ACTIVE) || (st_nx == PK_DECAY);
    assign pk_hi_q  = (st_q == PK_ACTIVE) || (st_q == PK_DECAY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PK_QUIET;
        end else begin
            st_q <= st_nx;
        end
    end

    // Output register: follower passes the tone, packet shows the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_out <= 1'b0;
        end else if (follow) begin
            ch_out <= tone;
        end else begin
            ch_out <= pk_hi_nx;
        end
    end

    assert_set_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pk_hi_q) |-> cnt == TOP);

    assert_clear_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pk_hi_q) |-> cnt == '0);

    assert_decay_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PK_DECAY) |-> (cnt != '0) && (cnt != TOP));

    assert_build_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PK_BUILD) |-> (cnt != '0) && (cnt != TOP));

    assert_quiet_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PK_QUIET) |-> cnt == '0);

    assert_mode_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !follow) |=> !ch_out);

endmodule

// File: rtl/tone_out_cond.sv
module tone_out_cond
    import tdo_pkg::*;
#(
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned CLK_HZ    = 3579545,
    parameter int unsigned WIN_MS    = 40,
    parameter int unsigned WIN_TICKS = win_ticks(CLK_HZ, WIN_MS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tone_in,
    input  logic              out_sel,
    input  logic              hiz_req,
    output logic [NUM_CH-1:0] ch_out,
    output logic              ch_drv
);

    logic mode_clr;

    tdo_mode_ctrl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_sel  (out_sel),
        .hiz_req  (hiz_req),
        .mode_clr (mode_clr),
        .drv_q    (ch_drv)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tdo_channel #(
            .TOP_VAL (WIN_TICKS)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tone   (tone_in[g]),
            .follow (out_sel),
            .clr    (mode_clr),
            .ch_out (ch_out[g])
        );
    end

    assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel |=> ch_out == $past(tone_in));

    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |-> (ch_out == '0) && !ch_drv);

endmodule

// File: tb/tone_out_cond_tb.sv
module tone_out_cond_tb;

    localparam int unsigned NCH = 2;
    localparam int unsigned WIN = 4;
    localparam int NVEC = 28;

    // Vector fields: [6]=out_sel [5]=hiz_req [4:3]=tone_in [2:1]=exp ch_out [0]=exp ch_drv
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_0_01_00_1, 7'b0_0_01_00_1, 7'b0_0_00_00_1, 7'b0_0_11_00_1,
        7'b0_0_11_00_1, 7'b0_0_11_01_1, 7'b0_0_11_11_1, 7'b0_0_11_11_1,
        7'b0_0_10_11_1, 7'b0_0_01_11_1, 7'b0_0_00_11_1, 7'b0_0_00_11_1,
        7'b0_0_00_01_1, 7'b0_0_00_00_1, 7'b0_0_00_00_1, 7'b0_1_00_00_0,
        7'b0_0_00_00_1, 7'b1_0_10_10_1, 7'b1_0_01_01_1, 7'b1_1_11_11_0,
        7'b0_0_11_00_1, 7'b0_0_11_00_1, 7'b0_0_11_00_1, 7'b0_0_11_00_1,
        7'b0_0_11_11_1, 7'b1_0_11_11_1, 7'b0_0_11_00_1, 7'b0_0_00_00_1
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] tone_in = '0;
    logic           out_sel = 1'b0;
    logic           hiz_req = 1'b0;
    logic [NCH-1:0] ch_out;
    logic           ch_drv;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tone_out_cond #(
        .NUM_CH    (NCH),
        .WIN_TICKS (WIN)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tone_in (tone_in),
        .out_sel (out_sel),
        .hiz_req (hiz_req),
        .ch_out  (ch_out),
        .ch_drv  (ch_drv)
    );

    function automatic string req_of(input int i);
        if (i <= 2)        return "R3";
        else if (i <= 5)   return "R1";
        else if (i <= 7)   return "R5";
        else if (i <= 11)  return "R6";
        else if (i <= 14)  return "R4";
        else if (i <= 16)  return "R8";
        else if (i <= 19)  return "R2";
        else if (i <= 24)  return "R7";
        else               return "R7";
    endfunction

    task automatic chk(input string req, input logic [2:0] exp_v);
        logic [2:0] act;
        act = {ch_out, ch_drv};
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: {ch_out,ch_drv} actual=%b expected=%b at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (2) @(negedge clk);
        chk("R9", 3'b00_0);
        rst_n = 1'b1;

        // Vector walk (WIN = 4); each vector is checked one clock after it is applied
        for (int i = 0; i < NVEC; i++) begin
            out_sel = VEC[i][6];
            hiz_req = VEC[i][5];
            tone_in = VEC[i][4:3];
            @(negedge clk);
            chk(req_of(i), VEC[i][2:0]);
        end

        // R10 / R3: a parameterised window of WIN tone cycles charges both channels
        out_sel = 1'b0;
        hiz_req = 1'b0;
        tone_in = 2'b11;
        for (int k = 1; k <= int'(WIN); k++) begin
            @(negedge clk);
            chk((k == int'(WIN)) ? "R10" : "R3", (k == int'(WIN)) ? 3'b11_1 : 3'b00_1);
        end

        // R5: extra tone beyond the top does not extend the release
        repeat (3) @(negedge clk);
        tone_in = 2'b00;
        for (int k = 1; k <= int'(WIN); k++) begin
            @(negedge clk);
            chk("R5", (k == int'(WIN)) ? 3'b00_1 : 3'b11_1);
        end

        // R9: reset while outputs are high
        tone_in = 2'b11;
        repeat (int'(WIN)) @(negedge clk);
        chk("R3", 3'b11_1);
        rst_n = 1'b0;
        #1;
        chk("R9", 3'b00_0);
        @(negedge clk);
        rst_n = 1'b1;
        tone_in = 2'b00;
        @(negedge clk);
        chk("R9", 3'b00_1);

        finish_run();
    end

endmodule